// File: doc/BRIEF.md
# Graphics Color-Fill and Bit-Mask Write Unit

This block is the write datapath in front of a graphics memory array. It turns one command per clock into a registered vector of per-bit write enables and write data for a group of eight adjacent columns. The array applies that vector in a single operation. A special-function input picks the extended operations. These are loading a 32-bit protection mask, loading a 32-bit fill color, a write that honours the protection mask, and a block fill. The block fill paints any subset of the eight columns with the stored color.

Four active-high byte-mask inputs block byte lanes during every kind of write. During a read, the same inputs decide which output lanes are driven in the following cycle. All results appear one clock after the command is sampled. A register load changes the behaviour of commands sampled from the next edge on.

Top module: `gfx_wr_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_wen`, `out_data`, `out_col_base` and `rd_lane_oe` are all zero. The protection mask holds all ones, so every bit is writable, and the fill color holds zero.
- R2: A write with `cmd_special` low is a plain write. One cycle later it enables only column `col_addr[2:0]` of the group. That column carries `wr_data`, and its bit k is enabled unless `byte_mask[k/8]` is 1. The protection mask is not applied. All other columns have zero enables and zero data.
- R3: A write with `cmd_special`, `cmd_load` high and `cmd_load_color` low stores `wr_data` in the protection mask. `byte_mask` is ignored for this load. The cycle produces no write (`out_valid` 0).
- R4: A write with `cmd_special`, `cmd_load` and `cmd_load_color` high stores `wr_data` in the fill color, ignoring `byte_mask`, and produces no write.
- R5: A write with `cmd_special` high and `cmd_load` and `cmd_block` low is a masked write. It behaves like R2, except that bit k is enabled only if protection-mask bit k is also 1.
- R6: A write with `cmd_special` and `cmd_block` high and `cmd_load` low is a block fill. Column c of the group (c = 0..7) is enabled when `wr_data[c]` is 1. Every enabled column carries the fill color. Bit k of an enabled column is enabled when protection-mask bit k is 1 and `byte_mask[k/8]` is 0. `col_addr[2:0]` has no effect, and columns that are not enabled carry zero data.
- R7: The protection mask and fill color keep their values across any number of writes and reads until the next load.
- R8: The cycle after a read (`cmd_valid` high, `cmd_write` low), `rd_lane_oe[i]` is the inverse of `byte_mask[i]`. After any other command it is all zero. A read produces no write.
- R9: For every write, `out_col_base` is `col_addr` with its low three bits cleared.
- R10: With `cmd_valid` low, the next cycle shows `out_valid` 0 and all-zero `out_wen`, `out_data` and `out_col_base`.
- R11: When both `cmd_load` and `cmd_block` are high with `cmd_special`, the command is a register load and no fill takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_write | input | 1 | 1 = write-type command, 0 = read |
| cmd_special | input | 1 | Selects loads, masked writes and block fills |
| cmd_block | input | 1 | With special: block fill |
| cmd_load | input | 1 | With special: register load |
| cmd_load_color | input | 1 | For a load: 1 = fill color, 0 = protection mask |
| col_addr | input | COL_AW (8) | Column address of the command |
| wr_data | input | DATA_W (32) | Write data, register value, or column enables for a fill |
| byte_mask | input | DATA_W/8 (4) | Per-lane block, active high |
| out_valid | output | 1 | A write vector is presented |
| out_col_base | output | COL_AW (8) | Aligned first column of the group |
| out_wen | output | COLS*DATA_W (256) | Per-column, per-bit write enable; column c at bits c*32 upward |
| out_data | output | COLS*DATA_W (256) | Per-column write data, same layout |
| rd_lane_oe | output | DATA_W/8 (4) | Output-lane enables for the read issued last cycle |

## Verification
The bench builds the unit with its default parameters: 32-bit words, eight columns per group and an 8-bit column address. With these values, random addresses reach every column slot in a group, including the last group at address 0xF8–0xFF. Random 32-bit masks, colors and column-enable bytes combine partial protection, partial lane blocking and sparse fills in the same command. Directed cases cover the reset values of both registers, loads that carry an ignored lane mask, and the load-over-fill priority.

// File: rtl/gfx_wr_pkg.sv
package gfx_wr_pkg;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_READ     = 3'd1,
        OP_PLAIN    = 3'd2,
        OP_MASKED   = 3'd3,
        OP_FILL     = 3'd4,
        OP_LD_PROT  = 3'd5,
        OP_LD_COLOR = 3'd6
    } gfx_op_e;

endpackage

// File: rtl/gfx_cmd_decode.sv
module gfx_cmd_decode
    import gfx_wr_pkg::*;
(
    input  logic    cmd_valid,
    input  logic    cmd_write,
    input  logic    cmd_special,
    input  logic    cmd_block,
    input  logic    cmd_load,
    input  logic    cmd_load_color,
    output gfx_op_e op
);

    always_comb begin
        op = OP_IDLE;
        if (cmd_valid) begin
            if (!cmd_write) begin
                op = OP_READ;
            end else if (!cmd_special) begin
                op = OP_PLAIN;
            end else if (cmd_load) begin
                // register load wins over block fill
                op = cmd_load_color ? OP_LD_COLOR : OP_LD_PROT;
            end else if (cmd_block) begin
                op = OP_FILL;
            end else begin
                op = OP_MASKED;
            end
        end
    end

endmodule

// File: rtl/gfx_lane_mask.sv
module gfx_lane_mask #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic [LANES-1:0]  byte_mask,
    input  logic [DATA_W-1:0] bit_mask,
    output logic [DATA_W-1:0] bit_en
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign bit_en[l*8 +: 8] = bit_mask[l*8 +: 8] & {8{~byte_mask[l]}};
    end

endmodule

// File: rtl/gfx_col_fill.sv
module gfx_col_fill #(
    parameter int DATA_W = 32,
    parameter int COLS   = 8,
    localparam int VEC_W = COLS * DATA_W
) (
    input  logic [COLS-1:0]   col_en,
    input  logic [DATA_W-1:0] bit_en,
    input  logic [DATA_W-1:0] src,
    output logic [VEC_W-1:0]  wen,
    output logic [VEC_W-1:0]  data
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign wen[c*DATA_W +: DATA_W]  = {DATA_W{col_en[c]}} & bit_en;
        assign data[c*DATA_W +: DATA_W] = {DATA_W{col_en[c]}} & src;
    end

endmodule

// File: rtl/gfx_wr_unit.sv
module gfx_wr_unit
    import gfx_wr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int COLS   = 8,
    parameter int COL_AW = 8,
    localparam int LANES  = DATA_W / 8,
    localparam int VEC_W  = COLS * DATA_W,
    localparam int CSEL_W = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic              cmd_special,
    input  logic              cmd_block,
    input  logic              cmd_load,
    input  logic              cmd_load_color,
    input  logic [COL_AW-1:0] col_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  byte_mask,
    output logic              out_valid,
    output logic [COL_AW-1:0] out_col_base,
    output logic [VEC_W-1:0]  out_wen,
    output logic [VEC_W-1:0]  out_data,
    output logic [LANES-1:0]  rd_lane_oe
);

    typedef struct packed {
        logic [DATA_W-1:0] prot;
        logic [DATA_W-1:0] color;
        logic              vld;
        logic [COL_AW-1:0] base;
        logic [VEC_W-1:0]  wen;
        logic [VEC_W-1:0]  data;
        logic [LANES-1:0]  oe;
    } unit_st_t;

    unit_st_t st_d, st_q;
    gfx_op_e  op;

    logic [DATA_W-1:0] act_mask;
    logic [DATA_W-1:0] bit_en;
    logic [DATA_W-1:0] src_word;
    logic [COLS-1:0]   slot_onehot;
    logic [COLS-1:0]   col_en;
    logic [VEC_W-1:0]  fill_wen;
    logic [VEC_W-1:0]  fill_data;

    gfx_cmd_decode u_dec (
        .cmd_valid      (cmd_valid),
        .cmd_write      (cmd_write),
        .cmd_special    (cmd_special),
        .cmd_block      (cmd_block),
        .cmd_load       (cmd_load),
        .cmd_load_color (cmd_load_color),
        .op             (op)
    );

    always_comb begin
        slot_onehot = COLS'(1) << col_addr[CSEL_W-1:0];
        act_mask    = (op == OP_PLAIN) ? {DATA_W{1'b1}} : st_q.prot;
        src_word    = (op == OP_FILL) ? st_q.color : wr_data;
        unique case (op)
            OP_PLAIN, OP_MASKED: col_en = slot_onehot;
            OP_FILL:             col_en = wr_data[COLS-1:0];
            default:             col_en = '0;
        endcase
    end

    gfx_lane_mask #(.DATA_W(DATA_W)) u_lane (
        .byte_mask (byte_mask),
        .bit_mask  (act_mask),
        .bit_en    (bit_en)
    );

    gfx_col_fill #(.DATA_W(DATA_W), .COLS(COLS)) u_fill (
        .col_en (col_en),
        .bit_en (bit_en),
        .src    (src_word),
        .wen    (fill_wen),
        .data   (fill_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.base = '0;
        st_d.wen  = '0;
        st_d.data = '0;
        st_d.oe   = '0;
        unique case (op)
            OP_LD_PROT:  st_d.prot  = wr_data;
            OP_LD_COLOR: st_d.color = wr_data;
            OP_READ:     st_d.oe    = ~byte_mask;
            OP_PLAIN, OP_MASKED, OP_FILL: begin
                st_d.vld  = 1'b1;
                st_d.base = {col_addr[COL_AW-1:CSEL_W], {CSEL_W{1'b0}}};
                st_d.wen  = fill_wen;
                st_d.data = fill_data;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prot  <= {DATA_W{1'b1}};
            st_q.color <= '0;
            st_q.vld   <= 1'b0;
            st_q.base  <= '0;
            st_q.wen   <= '0;
            st_q.data  <= '0;
            st_q.oe    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.vld;
    assign out_col_base = st_q.base;
    assign out_wen      = st_q.wen;
    assign out_data     = st_q.data;
    assign rd_lane_oe   = st_q.oe;

endmodule

// File: rtl/gfx_wr_unit_chk.sv
module gfx_wr_unit_chk #(
    parameter int DATA_W = 32,
    parameter int COLS   = 8,
    parameter int COL_AW = 8,
    localparam int LANES  = DATA_W / 8,
    localparam int VEC_W  = COLS * DATA_W,
    localparam int CSEL_W = $clog2(COLS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_write,
    input logic              cmd_special,
    input logic              cmd_block,
    input logic              cmd_load,
    input logic [COLS-1:0]   blk_bits,
    input logic [LANES-1:0]  byte_mask,
    input logic              out_valid,
    input logic [CSEL_W-1:0] base_low,
    input logic [VEC_W-1:0]  out_wen,
    input logic [LANES-1:0]  rd_lane_oe
);

    logic [COLS-1:0] col_any;
    for (genvar c = 0; c < COLS; c++) begin : g_any
        assign col_any[c] = |out_wen[c*DATA_W +: DATA_W];
    end

    logic is_wr, is_fill, is_load;
    assign is_wr   = cmd_valid && cmd_write;
    assign is_load = is_wr && cmd_special && cmd_load;
    assign is_fill = is_wr && cmd_special && !cmd_load && cmd_block;

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_wr |=> (!out_valid && out_wen == '0));

    assert_load_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> !out_valid);

    assert_base_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> base_low == '0);

    assert_one_column_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && !cmd_special) |=> $onehot0(col_any));

    assert_fill_columns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_fill |=> ((col_any & ~$past(blk_bits)) == '0));

    assert_read_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write) |=> (rd_lane_oe == ~$past(byte_mask)));

endmodule

bind gfx_wr_unit gfx_wr_unit_chk #(
    .DATA_W (DATA_W),
    .COLS   (COLS),
    .COL_AW (COL_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .cmd_special (cmd_special),
    .cmd_block   (cmd_block),
    .cmd_load    (cmd_load),
    .blk_bits    (wr_data[COLS-1:0]),
    .byte_mask   (byte_mask),
    .out_valid   (out_valid),
    .base_low    (out_col_base[CSEL_W-1:0]),
    .out_wen     (out_wen),
    .rd_lane_oe  (rd_lane_oe)
);

// File: tb/tb_gfx_wr_unit.sv
module tb_gfx_wr_unit;

    localparam int DATA_W = 32;
    localparam int COLS   = 8;
    localparam int COL_AW = 8;
    localparam int LANES  = DATA_W / 8;
    localparam int VEC_W  = COLS * DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0, cmd_write = 1'b0, cmd_special = 1'b0;
    logic              cmd_block = 1'b0, cmd_load = 1'b0, cmd_load_color = 1'b0;
    logic [COL_AW-1:0] col_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [LANES-1:0]  byte_mask = '0;
    logic              out_valid;
    logic [COL_AW-1:0] out_col_base;
    logic [VEC_W-1:0]  out_wen, out_data;
    logic [LANES-1:0]  rd_lane_oe;

    int checks = 0;
    int failures = 0;

    logic [DATA_W-1:0] m_prot  = '1;
    logic [DATA_W-1:0] m_color = '0;

    always #10 clk = ~clk;

    gfx_wr_unit #(.DATA_W(DATA_W), .COLS(COLS), .COL_AW(COL_AW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_special(cmd_special), .cmd_block(cmd_block), .cmd_load(cmd_load),
        .cmd_load_color(cmd_load_color), .col_addr(col_addr), .wr_data(wr_data),
        .byte_mask(byte_mask), .out_valid(out_valid), .out_col_base(out_col_base),
        .out_wen(out_wen), .out_data(out_data), .rd_lane_oe(rd_lane_oe)
    );

    task automatic check_vec(input string req, input string what,
                             input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input logic v, input logic w, input logic sp,
                        input logic bk, input logic ld, input logic lc,
                        input logic [COL_AW-1:0] a, input logic [DATA_W-1:0] d,
                        input logic [LANES-1:0] bm);
        logic is_wr, is_rd, is_load, is_fill, is_masked, is_plain, colen;
        logic [DATA_W-1:0] bitm, src;
        logic [VEC_W-1:0]  e_wen, e_data;
        logic [LANES-1:0]  e_oe;
        logic [COL_AW-1:0] e_base;
        @(negedge clk);
        cmd_valid = v; cmd_write = w; cmd_special = sp; cmd_block = bk;
        cmd_load = ld; cmd_load_color = lc; col_addr = a; wr_data = d; byte_mask = bm;
        is_wr     = v && w;
        is_rd     = v && !w;
        is_plain  = is_wr && !sp;
        is_load   = is_wr && sp && ld;
        is_fill   = is_wr && sp && !ld && bk;
        is_masked = is_wr && sp && !ld && !bk;
        bitm = is_plain ? '1 : m_prot;
        src  = is_fill ? m_color : d;
        e_wen = '0; e_data = '0;
        for (int c = 0; c < COLS; c++) begin
            colen = (is_plain || is_masked) ? (a[2:0] == c[2:0]) : (is_fill ? d[c] : 1'b0);
            for (int k = 0; k < DATA_W; k++)
                e_wen[c*DATA_W + k] = colen && bitm[k] && !bm[k/8];
            e_data[c*DATA_W +: DATA_W] = colen ? src : '0;
        end
        e_oe   = is_rd ? ~bm : '0;
        e_base = (is_plain || is_masked || is_fill) ? {a[COL_AW-1:3], 3'b000} : '0;
        @(posedge clk);
        #2;
        check_vec(req, "out_valid", VEC_W'(out_valid), VEC_W'(is_plain || is_masked || is_fill));
        check_vec(req, "out_col_base", VEC_W'(out_col_base), VEC_W'(e_base));
        check_vec(req, "out_wen", out_wen, e_wen);
        check_vec(req, "out_data", out_data, e_data);
        check_vec(req, "rd_lane_oe", VEC_W'(rd_lane_oe), VEC_W'(e_oe));
        if (is_load) begin
            if (lc) m_color = d; else m_prot = d;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_sink;
        int unsigned r;
        seed_sink = $urandom(32'd1357);
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state of outputs
        check_vec("R1", "out_valid", VEC_W'(out_valid), '0);
        check_vec("R1", "out_wen", out_wen, '0);
        check_vec("R1", "rd_lane_oe", VEC_W'(rd_lane_oe), '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: mask resets to all ones, color to zero
        step("R1", 1, 1, 1, 0, 0, 0, 8'h13, 32'hDEADBEEF, 4'b0000);
        step("R1", 1, 1, 1, 1, 0, 0, 8'h20, 32'h000000FF, 4'b0000);
        // R3: load protection mask, lane mask ignored
        step("R3", 1, 1, 1, 0, 1, 0, 8'h00, 32'hF0F0_0FF0, 4'b1111);
        // R5 and R7: masked writes reuse stored mask
        step("R5", 1, 1, 1, 0, 0, 0, 8'h45, 32'h1234_5678, 4'b0010);
        step("R7", 1, 1, 1, 0, 0, 0, 8'h46, 32'hFFFF_FFFF, 4'b0000);
        // R2: plain write ignores the protection mask
        step("R2", 1, 1, 0, 0, 0, 0, 8'h07, 32'hCAFE_F00D, 4'b0101);
        // R4: load color with lanes blocked
        step("R4", 1, 1, 1, 0, 1, 1, 8'h00, 32'hA5C3_9617, 4'b1111);
        // R6: fill, low address bits ignored
        step("R6", 1, 1, 1, 1, 0, 0, 8'h37, 32'h0000_00A5, 4'b1000);
        step("R6", 1, 1, 1, 1, 0, 0, 8'h30, 32'hFFFF_FF00, 4'b0000);
        // R8: read lane enables, then R10 idle
        step("R8", 1, 0, 0, 0, 0, 0, 8'h10, 32'h0, 4'b1010);
        step("R10", 0, 1, 1, 1, 0, 0, 8'h55, 32'hFFFF_FFFF, 4'b0000);
        // R11: load beats fill
        step("R11", 1, 1, 1, 1, 1, 0, 8'h08, 32'hFFFF_FFFF, 4'b0000);
        step("R7", 1, 1, 1, 1, 0, 0, 8'h08, 32'h0000_00FF, 4'b0000);
        // R9: top group
        step("R9", 1, 1, 0, 0, 0, 0, 8'hFF, 32'h0102_0304, 4'b0000);
        for (int i = 0; i < 600; i++) begin
            r = $urandom;
            step(r[2:0] == 3'd0 ? "R8" : (r[2:0] == 3'd1 ? "R3" : (r[2:0] == 3'd2 ? "R4" :
                 (r[2:0] == 3'd3 ? "R6" : (r[2:0] == 3'd4 ? "R5" : "R2")))),
                 r[2:0] != 3'd7, r[2:0] != 3'd0, r[2:0] inside {3'd1, 3'd2, 3'd3, 3'd4},
                 r[2:0] == 3'd3, r[2:0] inside {3'd1, 3'd2}, r[2:0] == 3'd2,
                 COL_AW'($urandom), $urandom, LANES'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule